// File: doc/BRIEF.md
# Shared-Memory Transfer Arbiter

This block sits between one memory slave port and two DMA engines: a camera engine that writes captured lines into memory and a display engine that reads lines back out to refill the screen buffer. The memory port returns a single wait-request line, so only one engine may drive the port at a time. The arbiter hands the port over for a whole line transfer, not for a single beat. The owning engine keeps the port until it reports the end of its transfer with a one-cycle done pulse.

When both engines ask at once, the display engine wins. A gap in the display refill corrupts the picture, while the camera side can absorb some delay. The arbiter never preempts a running transfer. After each transfer the port goes through one idle cycle before the next owner is chosen. While the port is owned, the arbiter forwards that engine's strobes, address and write data to the memory and returns the memory's wait-request to that engine only. The other engine sees a constant stall. A saturating counter records how often the camera had to wait longer than a limit set at an input port.

Top module: `shared_mem_arbiter`

## Requirements
- R1: At most one of `disp_gnt` and `cam_gnt` is high in any cycle.
- R2: From idle (no grant), if `disp_req` is high at a clock edge, `disp_gnt` is high after that edge, whether or not `cam_req` is also high.
- R3: A grant is held until the granted engine's own done input is sampled high. Dropping its request, or a done pulse from the other engine, does not end the grant.
- R4: In the cycle after a grant ends, neither grant is high.
- R5: While the display is granted, `mem_read` follows `disp_read`, `mem_addr` equals `disp_addr` and `mem_write` is 0. While the camera is granted, `mem_write` follows `cam_write`, `mem_addr` equals `cam_addr`, `mem_wdata` equals `cam_wdata` and `mem_read` is 0. `disp_rdata` always equals `mem_rdata`.
- R6: The granted engine's wait-request output equals `mem_waitreq`. An engine without a grant sees its wait-request output at 1.
- R7: With no grant, `mem_read` and `mem_write` are both 0.
- R8: `late_count` increases by one for each camera waiting episode that lasts more than `wait_limit` cycles. A waiting cycle is a clock edge at which `cam_req` is 1 and `cam_gnt` is 0. The counter counts at most once per episode and holds at its all-ones value.
- R9: While `rst` is high, both grants, `late_count`, `mem_read` and `mem_write` are 0.
- R10: From idle, with neither request high, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_req | input | 1 | Display engine asks for the port |
| disp_done | input | 1 | One-cycle pulse: display transfer finished |
| disp_read | input | 1 | Display read strobe |
| disp_addr | input | ADDR_W | Display address |
| disp_waitreq | output | 1 | Stall returned to the display engine |
| disp_rdata | output | DATA_W | Read data to the display engine |
| disp_gnt | output | 1 | Display owns the port |
| cam_req | input | 1 | Camera engine asks for the port |
| cam_done | input | 1 | One-cycle pulse: camera transfer finished |
| cam_write | input | 1 | Camera write strobe |
| cam_addr | input | ADDR_W | Camera address |
| cam_wdata | input | DATA_W | Camera write data |
| cam_waitreq | output | 1 | Stall returned to the camera engine |
| cam_gnt | output | 1 | Camera owns the port |
| mem_read | output | 1 | Read strobe to memory |
| mem_write | output | 1 | Write strobe to memory |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_waitreq | input | 1 | Wait-request from memory |
| wait_limit | input | LIMIT_W | Camera waiting threshold in cycles |
| late_count | output | CNT_W | Saturating count of over-limit camera waits |

## Verification
On every cycle, the assertions check grant exclusivity, display priority from idle, grant holding, the idle gap, refusal to grant without a request, port routing, wait-request steering, quiet strobes when idle, and the one-step and saturating behaviour of the late counter. Some behaviour only the bench scenarios can show. These are: the camera getting its turn once the display finishes, done pulses from the wrong engine being ignored, and the late counter matching an arithmetic count of waiting cycles. The bench sweeps several thresholds against several display hold lengths until the counter saturates.

// File: rtl/sma_pkg.sv
package sma_pkg;
  localparam int NUM_ENG  = 2;
  localparam int ENG_DISP = 0;
  localparam int ENG_CAM  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DISP = 2'd1,
    ST_CAM  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/sma_grant_fsm.sv
module sma_grant_fsm
  import sma_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ENG-1:0] req,
  input  logic [NUM_ENG-1:0] done,
  output logic [NUM_ENG-1:0] gnt
);
  arb_state_t state_q;

  // Whole-transfer grant: idle -> owner -> idle, display checked first.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gnt     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req[ENG_DISP]) begin
            state_q <= ST_DISP;
            gnt     <= NUM_ENG'(1) << ENG_DISP;
          end else if (req[ENG_CAM]) begin
            state_q <= ST_CAM;
            gnt     <= NUM_ENG'(1) << ENG_CAM;
          end
        end
        ST_DISP: begin
          if (done[ENG_DISP]) begin
            state_q <= ST_IDLE;
            gnt     <= '0;
          end
        end
        ST_CAM: begin
          if (done[ENG_CAM]) begin
            state_q <= ST_IDLE;
            gnt     <= '0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          gnt     <= '0;
        end
      endcase
    end
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt) <= 1);

  assert_disp_first_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req[ENG_DISP]) |=> gnt[ENG_DISP]);

  assert_hold_disp_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt[ENG_DISP] && !done[ENG_DISP]) |=> gnt[ENG_DISP]);

  assert_hold_cam_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt[ENG_CAM] && !done[ENG_CAM]) |=> gnt[ENG_CAM]);

  assert_gap_disp_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt[ENG_DISP] && done[ENG_DISP]) |=> gnt == '0);

  assert_gap_cam_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt[ENG_CAM] && done[ENG_CAM]) |=> gnt == '0);

  assert_no_req_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> gnt == '0);
endmodule

// File: rtl/sma_port_mux.sv
module sma_port_mux #(
  parameter int N      = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]             gnt,
  input  logic [N-1:0]             rd,
  input  logic [N-1:0]             wr,
  input  logic [N-1:0][ADDR_W-1:0] addr,
  input  logic [N-1:0][DATA_W-1:0] wdata,
  input  logic                     mem_waitreq,
  output logic                     mem_read,
  output logic                     mem_write,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [N-1:0]             eng_waitreq
);
  logic [N-1:0]             rd_m;
  logic [N-1:0]             wr_m;
  logic [N-1:0][ADDR_W-1:0] addr_m;
  logic [N-1:0][DATA_W-1:0] wdata_m;

  // Per-engine gating: a term is live only under that engine's grant.
  for (genvar i = 0; i < N; i++) begin : g_eng
    assign rd_m[i]        = rd[i] & gnt[i];
    assign wr_m[i]        = wr[i] & gnt[i];
    assign addr_m[i]      = addr[i] & {ADDR_W{gnt[i]}};
    assign wdata_m[i]     = wdata[i] & {DATA_W{gnt[i]}};
    assign eng_waitreq[i] = gnt[i] ? mem_waitreq : 1'b1;
  end

  // AND-OR merge; grants are exclusive so at most one term is nonzero.
  always_comb begin
    mem_read  = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N; i++) begin
      mem_read  = mem_read | rd_m[i];
      mem_write = mem_write | wr_m[i];
      mem_addr  = mem_addr | addr_m[i];
      mem_wdata = mem_wdata | wdata_m[i];
    end
  end
endmodule

// File: rtl/sma_wait_monitor.sv
module sma_wait_monitor #(
  parameter int LIMIT_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               waiting,
  input  logic [LIMIT_W-1:0] limit,
  output logic [CNT_W-1:0]   late_count
);
  logic [LIMIT_W:0] wait_q;
  logic [LIMIT_W:0] limit_ext;

  assign limit_ext = {1'b0, limit};

  // wait_q stops at limit+1, so each episode can count at most once.
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q     <= '0;
      late_count <= '0;
    end else if (!waiting) begin
      wait_q <= '0;
    end else begin
      if (wait_q <= limit_ext) wait_q <= wait_q + 1'b1;
      if (wait_q == limit_ext && late_count != '1)
        late_count <= late_count + 1'b1;
    end
  end

  assert_late_step_R8: assert property (@(posedge clk) disable iff (rst)
    (late_count != $past(late_count)) |-> (late_count == $past(late_count) + 1'b1));

  assert_late_sat_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(late_count) == '1) |-> (late_count == '1));
endmodule

// File: rtl/shared_mem_arbiter.sv
module shared_mem_arbiter
  import sma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LIMIT_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_req,
  input  logic               disp_done,
  input  logic               disp_read,
  input  logic [ADDR_W-1:0]  disp_addr,
  output logic               disp_waitreq,
  output logic [DATA_W-1:0]  disp_rdata,
  output logic               disp_gnt,
  input  logic               cam_req,
  input  logic               cam_done,
  input  logic               cam_write,
  input  logic [ADDR_W-1:0]  cam_addr,
  input  logic [DATA_W-1:0]  cam_wdata,
  output logic               cam_waitreq,
  output logic               cam_gnt,
  output logic               mem_read,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_waitreq,
  input  logic [LIMIT_W-1:0] wait_limit,
  output logic [CNT_W-1:0]   late_count
);
  logic [NUM_ENG-1:0]             req_v, done_v, gnt_v, rd_v, wr_v, wreq_v;
  logic [NUM_ENG-1:0][ADDR_W-1:0] addr_v;
  logic [NUM_ENG-1:0][DATA_W-1:0] wdata_v;

  always_comb begin
    req_v            = '0;
    done_v           = '0;
    rd_v             = '0;
    wr_v             = '0;
    addr_v           = '0;
    wdata_v          = '0;
    req_v[ENG_DISP]  = disp_req;
    req_v[ENG_CAM]   = cam_req;
    done_v[ENG_DISP] = disp_done;
    done_v[ENG_CAM]  = cam_done;
    rd_v[ENG_DISP]   = disp_read;
    wr_v[ENG_CAM]    = cam_write;
    addr_v[ENG_DISP] = disp_addr;
    addr_v[ENG_CAM]  = cam_addr;
    wdata_v[ENG_CAM] = cam_wdata;
  end

  sma_grant_fsm u_fsm (
    .clk  (clk),
    .rst  (rst),
    .req  (req_v),
    .done (done_v),
    .gnt  (gnt_v)
  );

  sma_port_mux #(.N(NUM_ENG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .gnt         (gnt_v),
    .rd          (rd_v),
    .wr          (wr_v),
    .addr        (addr_v),
    .wdata       (wdata_v),
    .mem_waitreq (mem_waitreq),
    .mem_read    (mem_read),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .eng_waitreq (wreq_v)
  );

  sma_wait_monitor #(.LIMIT_W(LIMIT_W), .CNT_W(CNT_W)) u_mon (
    .clk        (clk),
    .rst        (rst),
    .waiting    (cam_req & ~gnt_v[ENG_CAM]),
    .limit      (wait_limit),
    .late_count (late_count)
  );

  assign disp_gnt     = gnt_v[ENG_DISP];
  assign cam_gnt      = gnt_v[ENG_CAM];
  assign disp_waitreq = wreq_v[ENG_DISP];
  assign cam_waitreq  = wreq_v[ENG_CAM];
  assign disp_rdata   = mem_rdata;

  assert_route_disp_R5: assert property (@(posedge clk) disable iff (rst)
    disp_gnt |-> (mem_addr == disp_addr && mem_read == disp_read && !mem_write));

  assert_route_cam_R5: assert property (@(posedge clk) disable iff (rst)
    cam_gnt |-> (mem_addr == cam_addr && mem_wdata == cam_wdata &&
                 mem_write == cam_write && !mem_read));

  assert_steer_disp_R6: assert property (@(posedge clk) disable iff (rst)
    disp_gnt |-> (disp_waitreq == mem_waitreq && cam_waitreq));

  assert_steer_cam_R6: assert property (@(posedge clk) disable iff (rst)
    cam_gnt |-> (cam_waitreq == mem_waitreq && disp_waitreq));

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!disp_gnt && !cam_gnt) |-> (!mem_read && !mem_write));
endmodule

// File: tb/shared_mem_arbiter_bench.sv
module shared_mem_arbiter_bench;
  localparam int AW = 8, DW = 16, LW = 4, CW = 4;
  localparam int CNT_MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_req = 0, disp_done = 0, disp_read = 0;
  logic [AW-1:0] disp_addr = '0;
  logic disp_waitreq, disp_gnt;
  logic [DW-1:0] disp_rdata;
  logic cam_req = 0, cam_done = 0, cam_write = 0;
  logic [AW-1:0] cam_addr = '0;
  logic [DW-1:0] cam_wdata = '0;
  logic cam_waitreq, cam_gnt;
  logic mem_read, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_waitreq = 0;
  logic [LW-1:0] wait_limit = '1;
  logic [CW-1:0] late_count;

  int n_chk = 0, n_bad = 0, waited = 0, exp_late = 0;

  always #10 clk = ~clk;

  shared_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW), .LIMIT_W(LW), .CNT_W(CW)) u_shared_mem_arbiter (
    .clk(clk), .rst(rst),
    .disp_req(disp_req), .disp_done(disp_done), .disp_read(disp_read),
    .disp_addr(disp_addr), .disp_waitreq(disp_waitreq), .disp_rdata(disp_rdata),
    .disp_gnt(disp_gnt),
    .cam_req(cam_req), .cam_done(cam_done), .cam_write(cam_write),
    .cam_addr(cam_addr), .cam_wdata(cam_wdata), .cam_waitreq(cam_waitreq),
    .cam_gnt(cam_gnt),
    .mem_read(mem_read), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_waitreq(mem_waitreq),
    .wait_limit(wait_limit), .late_count(late_count)
  );

  // Camera waiting cycles, seen with the same values the next edge samples.
  always @(negedge clk) if (!rst && cam_req && !cam_gnt) waited++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic episode(input int d);
    int guard;
    waited = 0;
    if (d > 0) begin
      disp_req = 1; cam_req = 1;
      tick();
      @(negedge clk);
      check(disp_gnt && !cam_gnt, "R2 display first", {disp_gnt, cam_gnt}, 2);
      repeat (d - 1) tick();
      if (d == 1) tick();
      disp_req = 0; disp_done = 1;
      tick();
      disp_done = 0;
    end else begin
      cam_req = 1;
    end
    guard = 0;
    while (!cam_gnt && guard < 50) begin
      tick();
      guard++;
    end
    check(cam_gnt == 1, "R3 camera turn", cam_gnt, 1);
    cam_done = 1; cam_req = 0;
    tick();
    cam_done = 0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    @(negedge clk);
    check(!disp_gnt && !cam_gnt, "R9 reset grants", {disp_gnt, cam_gnt}, 0);
    check(late_count == 0, "R9 reset counter", late_count, 0);
    check(!mem_read && !mem_write, "R9 reset strobes", {mem_read, mem_write}, 0);
    rst = 0;
    repeat (3) tick();
    @(negedge clk);
    check(!disp_gnt && !cam_gnt, "R10 no request", {disp_gnt, cam_gnt}, 0);
    check(!mem_read && !mem_write, "R7 idle strobes", {mem_read, mem_write}, 0);

    // Display alone; camera drives its bus without requesting.
    disp_req = 1; disp_read = 1; disp_addr = 8'h5A;
    cam_write = 1; cam_addr = 8'h33; cam_wdata = 16'hBEEF;
    mem_waitreq = 1; mem_rdata = 16'h1234;
    tick();
    @(negedge clk);
    check(disp_gnt && !cam_gnt, "R2 display granted", {disp_gnt, cam_gnt}, 2);
    check(mem_read == 1 && mem_write == 0, "R5 display strobes", {mem_read, mem_write}, 2);
    check(mem_addr == 8'h5A, "R5 display addr", mem_addr, 8'h5A);
    check(disp_rdata == 16'h1234, "R5 read data", disp_rdata, 16'h1234);
    check(disp_waitreq && cam_waitreq, "R6 stall passed", {disp_waitreq, cam_waitreq}, 3);
    mem_waitreq = 0;
    #1;
    check(!disp_waitreq && cam_waitreq, "R6 other stalled", {disp_waitreq, cam_waitreq}, 1);

    // Request drop and foreign done must not end the display grant.
    disp_req = 0; cam_req = 1; cam_done = 1;
    tick();
    cam_done = 0;
    tick();
    @(negedge clk);
    check(disp_gnt && !cam_gnt, "R3 display held", {disp_gnt, cam_gnt}, 2);
    disp_done = 1;
    tick();
    disp_done = 0;
    @(negedge clk);
    check(!disp_gnt && !cam_gnt, "R4 idle gap", {disp_gnt, cam_gnt}, 0);
    tick();
    @(negedge clk);
    check(cam_gnt && !disp_gnt, "R3 camera after display", {disp_gnt, cam_gnt}, 1);
    check(mem_write == 1 && mem_read == 0, "R5 camera strobes", {mem_read, mem_write}, 1);
    check(mem_addr == 8'h33, "R5 camera addr", mem_addr, 8'h33);
    check(mem_wdata == 16'hBEEF, "R5 camera data", mem_wdata, 16'hBEEF);
    check(disp_waitreq && !cam_waitreq, "R6 camera steer", {disp_waitreq, cam_waitreq}, 2);
    disp_done = 1;
    tick();
    disp_done = 0;
    @(negedge clk);
    check(cam_gnt == 1, "R3 foreign done ignored", cam_gnt, 1);
    cam_done = 1; cam_req = 0;
    tick();
    cam_done = 0;
    @(negedge clk);
    check(!disp_gnt && !cam_gnt, "R4 gap after camera", {disp_gnt, cam_gnt}, 0);
    check(!mem_read && !mem_write, "R7 quiet after done", {mem_read, mem_write}, 0);
    check(late_count == 0, "R8 under limit", late_count, 0);
    disp_read = 0; cam_write = 0;
    tick();

    // Threshold sweep against display hold lengths (R8).
    for (int lim = 0; lim < 6; lim++) begin
      wait_limit = LW'(lim);
      for (int d = 0; d < 7; d++) begin
        episode(d);
        if (waited > lim && exp_late < CNT_MAX) exp_late++;
        check(int'(late_count) == exp_late, "R8 late count", late_count, exp_late);
      end
    end
    check(late_count == CW'(CNT_MAX), "R8 saturated", late_count, CNT_MAX);
    finish_run();
  end
endmodule